// File: doc/BRIEF.md
# PUF Soft-Decision Likelihood Front End

This block prepares the soft-decision input for an error-correcting decoder that works on one 256-bit segment of an SRAM power-up response. For every bit of the chosen segment it combines the raw power-up bit with a stored helper bit. It turns the stored error-probability count for that bit into a signed 16-bit log-likelihood. It then writes the likelihoods, two per 32-bit word, into the decoder's working RAM.

The full 1024-bit response is processed as four segments in turn through one decoder. The working RAM and the power-up source are overwritten once decoding starts. For that reason the job on segment 0 also copies the raw bits of segments 1 to 3 into an internal side buffer, and later jobs on those segments read their raw bits from that buffer.

The error probabilities are counts from 100 enrollment power-ups. Because the set of counts is small, a loadable magnitude table replaces any logarithm. The table holds 51 entries of 15 bits and is indexed by the folded count, so its mapping may be permuted freely.

Top module: `puf_llr_frontend`

## Requirements
- R1: After a synchronous reset, `busy`, `done`, `mem_rd` and `wr_en` are low.
- R2: When `start` is sampled high while `busy` is low, the block reads pair indices 0 to 127 in order, with `rom_addr` = {segment, index} and `pu_addr` = index. It writes 128 words with `wr_addr` 0 to 127 ascending, on consecutive cycles, and the first write is visible two clock edges after the edge that accepted `start`.
- R3: The ROM word holds two lanes: bits [6:0] are the count of even bit 2p, bit 7 is its helper bit, bits [14:8] are the count of odd bit 2p+1, and bit 15 is its helper bit. `wr_data[15:0]` holds the likelihood of bit 2p and `wr_data[31:16]` holds that of bit 2p+1.
- R4: For a count below 50, the likelihood is +magnitude when raw XOR helper is 0 and −magnitude (two's complement) when it is 1.
- R5: The magnitude for a folded count f (0..49) is entry f of the `MAG_TABLE` parameter, located at bits [f*15 +: 15], so any table may be loaded.
- R6: A count of exactly 50 yields likelihood 0 whatever the table entry holds.
- R7: A count c from 51 to 100 uses table entry 100−c with the sign inverted. A count above 100 is treated as 100.
- R8: During a segment-0 job, raw bits come from `pu_rdata[1:0]`, and `pu_rdata[7:2]` (2 bits per segment 1..3) are stored in the side buffer. Jobs on segments 1 to 3 take their raw bits from that buffer and ignore the power-up source.
- R9: A `start` that arrives while `busy` is high is ignored. The running job keeps its segment and still writes exactly 128 words.
- R10: `done` is high for exactly one cycle, on the cycle after the last write. No write follows `done` until the next job is started.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Job start pulse |
| seg_sel | input | 2 | Segment to process (0..3) |
| busy | output | 1 | Job in progress |
| done | output | 1 | One-cycle end-of-job pulse |
| mem_rd | output | 1 | Read enable for ROM and power-up source |
| rom_addr | output | 9 | ROM pair address {segment, index} |
| rom_rdata | input | 16 | ROM word, one cycle after the read |
| pu_addr | output | 7 | Power-up source pair index |
| pu_rdata | input | 8 | Raw bit pairs of all four segments at that index |
| wr_en | output | 1 | Working RAM write enable |
| wr_addr | output | 7 | Working RAM word address |
| wr_data | output | 32 | Packed likelihood pair |

## Verification
The hardest case to reach from the ports is a job on segments 1 to 3 whose raw bits must come from the side buffer and not from the power-up source. The bench runs a segment-0 job first and then scrambles the whole power-up model. Any word that still follows the live source shows up as a mismatch. A second segment-0 job with yet another source content then checks that the buffer is refilled. The forced zero at count 50 is only visible when the loaded table has a nonzero entry 50, so the bench loads such a table. A start pulse is also injected partway through a running job.

// File: rtl/puf_llr_pkg.sv
package puf_llr_pkg;

    localparam int ENROLL_MAX = 100;
    localparam int HALF       = ENROLL_MAX / 2;
    localparam int CNT_W      = $clog2(ENROLL_MAX + 1);
    localparam int LLR_W      = 16;
    localparam int MAG_W      = LLR_W - 1;
    localparam int TAB_N      = HALF + 1;
    localparam int TIDX_W     = $clog2(TAB_N);

    typedef logic [CNT_W-1:0]        cnt_t;
    typedef logic signed [LLR_W-1:0] llr_t;
    typedef logic [MAG_W-1:0]        mag_t;

    typedef struct packed {
        logic helper;
        cnt_t cnt;
    } aux_t;

    typedef struct packed {
        aux_t odd;
        aux_t even;
    } rom_word_t;

    typedef struct packed {
        logic              flip;
        logic [TIDX_W-1:0] idx;
    } fold_t;

    // Clamp to the enrollment maximum, then mirror the upper half.
    function automatic fold_t fold_count(cnt_t c);
        fold_t r;
        int    cc;
        cc     = (int'(c) > ENROLL_MAX) ? ENROLL_MAX : int'(c);
        r.flip = (cc > HALF);
        r.idx  = TIDX_W'(r.flip ? (ENROLL_MAX - cc) : cc);
        return r;
    endfunction

    // Default magnitudes: quadratic in distance from the midpoint.
    function automatic logic [TAB_N*MAG_W-1:0] default_table();
        logic [TAB_N*MAG_W-1:0] t;
        t = '0;
        for (int i = 0; i < TAB_N; i++) begin
            int d;
            d = HALF - i;
            t[i*MAG_W +: MAG_W] = MAG_W'(d * d * 13);
        end
        return t;
    endfunction

endpackage

// File: rtl/llr_lane.sv
module llr_lane
    import puf_llr_pkg::*;
#(
    parameter logic [TAB_N*MAG_W-1:0] MAG_TABLE = default_table()
)(
    input  logic raw,
    input  aux_t aux,
    output llr_t llr
);

    fold_t f;
    mag_t  mag;
    logic  neg;

    always_comb begin
        f   = fold_count(aux.cnt);
        mag = (int'(f.idx) == HALF) ? '0 : MAG_TABLE[int'(f.idx)*MAG_W +: MAG_W];
        neg = raw ^ aux.helper ^ f.flip;
        llr = neg ? -llr_t'({1'b0, mag}) : llr_t'({1'b0, mag});
    end

    always_comb begin
        if (aux.cnt == cnt_t'(HALF))
            AST_HALF_IS_ZERO: assert (llr == '0) else $error("half count not zero"); // R6
        if (aux.cnt == cnt_t'(ENROLL_MAX) && raw == aux.helper)
            AST_FULL_COUNT_NONPOS: assert (llr <= 0) else $error("mirror sign"); // R7
    end

endmodule

// File: rtl/raw_side_buf.sv
module raw_side_buf #(
    parameter int NUM_SEG = 4,
    parameter int PAIRS   = 128,
    localparam int IDX_W  = $clog2(PAIRS),
    localparam int SEG_W  = $clog2(NUM_SEG),
    localparam int HELD   = NUM_SEG - 1
)(
    input  logic               clk,
    input  logic               rst,
    input  logic               we,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [2*HELD-1:0]  wr_pairs,
    input  logic [SEG_W-1:0]   rd_seg,
    input  logic [IDX_W-1:0]   rd_idx,
    output logic [1:0]         rd_pair
);

    logic [1:0] store [HELD][PAIRS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < HELD; s++)
                for (int p = 0; p < PAIRS; p++)
                    store[s][p] <= '0;
        end else if (we) begin
            for (int s = 0; s < HELD; s++)
                store[s][wr_idx] <= wr_pairs[2*s +: 2];
        end
    end

    always_comb begin
        rd_pair = '0;
        for (int s = 0; s < HELD; s++)
            if (int'(rd_seg) == s + 1)
                rd_pair = store[s][rd_idx];
    end

endmodule

// File: rtl/llr_job_ctrl.sv
module llr_job_ctrl #(
    parameter int NUM_SEG = 4,
    parameter int PAIRS   = 128,
    localparam int IDX_W  = $clog2(PAIRS),
    localparam int SEG_W  = $clog2(NUM_SEG)
)(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [SEG_W-1:0] seg_sel,
    input  logic             fin,
    output logic             busy,
    output logic             issue,
    output logic [IDX_W-1:0] rd_idx,
    output logic [SEG_W-1:0] seg_q,
    output logic             s1_valid,
    output logic [IDX_W-1:0] s1_idx,
    output logic             s1_last
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(PAIRS - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy     <= 1'b0;
            issue    <= 1'b0;
            rd_idx   <= '0;
            seg_q    <= '0;
            s1_valid <= 1'b0;
            s1_idx   <= '0;
            s1_last  <= 1'b0;
        end else begin
            s1_valid <= issue;
            s1_idx   <= rd_idx;
            s1_last  <= issue && (rd_idx == LAST);
            if (start && !busy) begin
                busy   <= 1'b1;
                issue  <= 1'b1;
                rd_idx <= '0;
                seg_q  <= seg_sel;
            end else begin
                if (fin)
                    busy <= 1'b0;
                if (issue) begin
                    rd_idx <= rd_idx + 1'b1;
                    if (rd_idx == LAST)
                        issue <= 1'b0;
                end
            end
        end
    end

    AST_START_IGNORED_WHEN_BUSY: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> $stable(seg_q)) else $error("segment changed mid-job"); // R9
    AST_READ_ONLY_WHEN_BUSY: assert property (@(posedge clk) disable iff (rst)
        issue |-> busy) else $error("read outside job"); // R2

endmodule

// File: rtl/puf_llr_frontend.sv
module puf_llr_frontend
    import puf_llr_pkg::*;
#(
    parameter int SEG_BITS = 256,
    parameter int NUM_SEG  = 4,
    parameter logic [TAB_N*MAG_W-1:0] MAG_TABLE = default_table(),
    localparam int PAIRS  = SEG_BITS / 2,
    localparam int IDX_W  = $clog2(PAIRS),
    localparam int SEG_W  = $clog2(NUM_SEG),
    localparam int RAW_W  = 2 * NUM_SEG,
    localparam int ROM_AW = SEG_W + IDX_W,
    localparam int ROM_W  = $bits(rom_word_t),
    localparam int WORD_W = 2 * LLR_W
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [SEG_W-1:0]  seg_sel,
    output logic              busy,
    output logic              done,
    output logic              mem_rd,
    output logic [ROM_AW-1:0] rom_addr,
    input  logic [ROM_W-1:0]  rom_rdata,
    output logic [IDX_W-1:0]  pu_addr,
    input  logic [RAW_W-1:0]  pu_rdata,
    output logic              wr_en,
    output logic [IDX_W-1:0]  wr_addr,
    output logic [WORD_W-1:0] wr_data
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(PAIRS - 1);

    logic [SEG_W-1:0] seg_q;
    logic             s1_valid, s1_last, wr_last;
    logic [IDX_W-1:0] s1_idx;
    logic [1:0]       buf_pair, raw_pair;
    rom_word_t        rw;
    aux_t             lane_aux [2];
    llr_t             lane_llr [2];

    llr_job_ctrl #(.NUM_SEG(NUM_SEG), .PAIRS(PAIRS)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .seg_sel  (seg_sel),
        .fin      (wr_en && wr_last),
        .busy     (busy),
        .issue    (mem_rd),
        .rd_idx   (pu_addr),
        .seg_q    (seg_q),
        .s1_valid (s1_valid),
        .s1_idx   (s1_idx),
        .s1_last  (s1_last)
    );

    assign rom_addr = {seg_q, pu_addr};

    raw_side_buf #(.NUM_SEG(NUM_SEG), .PAIRS(PAIRS)) u_side (
        .clk      (clk),
        .rst      (rst),
        .we       (s1_valid && seg_q == '0),
        .wr_idx   (s1_idx),
        .wr_pairs (pu_rdata[RAW_W-1:2]),
        .rd_seg   (seg_q),
        .rd_idx   (s1_idx),
        .rd_pair  (buf_pair)
    );

    always_comb begin
        rw          = rom_word_t'(rom_rdata);
        lane_aux[0] = rw.even;
        lane_aux[1] = rw.odd;
        raw_pair    = (seg_q == '0) ? pu_rdata[1:0] : buf_pair;
    end

    for (genvar l = 0; l < 2; l++) begin : g_lane
        llr_lane #(.MAG_TABLE(MAG_TABLE)) u_lane (
            .raw (raw_pair[l]),
            .aux (lane_aux[l]),
            .llr (lane_llr[l])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_en   <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
            wr_last <= 1'b0;
            done    <= 1'b0;
        end else begin
            wr_en   <= s1_valid;
            wr_addr <= s1_idx;
            wr_last <= s1_last;
            wr_data <= {lane_llr[1], lane_llr[0]};
            done    <= wr_en && wr_last;
        end
    end

    AST_WRITE_SEQUENCE: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr != LAST) |=> (wr_en && wr_addr == IDX_W'($past(wr_addr) + 1'b1)))
        else $error("write order broken"); // R2
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done) else $error("done too long"); // R10
    AST_NO_WRITE_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
        done |-> !wr_en) else $error("write after done"); // R10
    AST_DONE_NEEDS_BUSY: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(busy)) else $error("done outside job"); // R10

endmodule

// File: tb/puf_llr_frontend_test.sv
module puf_llr_frontend_test;

    localparam int CLK_PERIOD = 10;
    localparam int NP = 128;
    localparam int TN = 51;
    localparam int MW = 15;

    function automatic int btab(int i);
        return (i * 523 + 97) % 30000;
    endfunction

    function automatic logic [TN*MW-1:0] mk_tab();
        logic [TN*MW-1:0] t;
        for (int i = 0; i < TN; i++) t[i*MW +: MW] = MW'(btab(i));
        return t;
    endfunction

    localparam logic [TN*MW-1:0] TB_TAB = mk_tab();

    logic        clk = 0, rst = 1, start = 0;
    logic [1:0]  seg_sel = 0;
    logic        busy, done, mem_rd, wr_en;
    logic [8:0]  rom_addr;
    logic [15:0] rom_rdata;
    logic [6:0]  pu_addr, wr_addr;
    logic [7:0]  pu_rdata;
    logic [31:0] wr_data;

    puf_llr_frontend #(.MAG_TABLE(TB_TAB)) uut (
        .clk(clk), .rst(rst), .start(start), .seg_sel(seg_sel),
        .busy(busy), .done(done), .mem_rd(mem_rd), .rom_addr(rom_addr),
        .rom_rdata(rom_rdata), .pu_addr(pu_addr), .pu_rdata(pu_rdata),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    logic [15:0] rom_mem [512];
    logic [7:0]  pu_mem  [NP];
    logic [1:0]  cap     [4][NP];

    always @(posedge clk) begin
        if (mem_rd) begin
            rom_rdata <= rom_mem[rom_addr];
            pu_rdata  <= pu_mem[pu_addr];
        end
    end

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int nchk = 0, nfail = 0;
    bit finished = 0;
    int nwr = 0, ndone = 0, first_cyc = 0, last_cyc = 0, done_cyc = 0;
    int cur_seg = 0;
    logic [31:0] got [NP];

    task automatic check(bit ok, string tag, longint act, longint exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            if (wr_en) begin
                check(wr_addr == 7'(nwr), "R2 write address order", wr_addr, nwr);
                got[wr_addr] = wr_data;
                if (nwr == 0) first_cyc = cyc;
                last_cyc = cyc;
                nwr++;
            end
            if (done) begin
                ndone++;
                done_cyc = cyc;
            end
            if (mem_rd && int'(rom_addr[8:7]) != cur_seg)
                check(0, "R2 rom segment field", rom_addr[8:7], cur_seg);
        end
    end

    function automatic logic [15:0] mdl(bit raw, bit h, int c);
        int cc, f, mag;
        bit fl, neg;
        cc  = (c > 100) ? 100 : c;
        fl  = cc > 50;
        f   = fl ? 100 - cc : cc;
        mag = (f == 50) ? 0 : btab(f);
        neg = raw ^ h ^ fl;
        return neg ? 16'(-mag) : 16'(mag);
    endfunction

    task automatic run_job(int s, string tag, bit poke);
        int t0, nd0, i;
        nwr = 0;
        nd0 = ndone;
        cur_seg = s;
        if (s == 0)
            for (int p = 0; p < NP; p++)
                for (int k = 1; k < 4; k++) cap[k][p] = pu_mem[p][2*k +: 2];
        @(negedge clk);
        seg_sel = 2'(s);
        start = 1;
        @(negedge clk);
        start = 0;
        t0 = cyc;
        i = 0;
        while (ndone == nd0 && i < 400) begin
            @(negedge clk);
            i++;
            if (poke && i == 40) begin
                seg_sel = 2'(s ^ 1);
                start = 1;
            end else begin
                start = 0;
            end
        end
        repeat (4) @(negedge clk);
        check(ndone - nd0 == 1, "R10 single done pulse", ndone - nd0, 1);
        check(nwr == NP, {tag, " R2 R9 write count"}, nwr, NP);
        check(first_cyc == t0 + 2, "R2 first write latency", first_cyc - t0, 2);
        check(done_cyc == last_cyc + 1, "R10 done after last write", done_cyc - last_cyc, 1);
        check(!busy, "R10 idle after done", busy, 0);
        for (int p = 0; p < NP; p++) begin
            logic [1:0]  rp;
            logic [15:0] rw;
            logic [31:0] e;
            rp = (s == 0) ? pu_mem[p][1:0] : cap[s][p];
            rw = rom_mem[s*NP + p];
            e  = {mdl(rp[1], rw[15], int'(rw[14:8])), mdl(rp[0], rw[7], int'(rw[6:0]))};
            check(got[p] === e, tag, got[p], e);
        end
    endtask

    task automatic fill_random();
        for (int a = 0; a < 512; a++)
            rom_mem[a] = {1'($urandom), 7'($urandom_range(0, 127)), 1'($urandom), 7'($urandom_range(0, 127))};
        for (int p = 0; p < NP; p++) pu_mem[p] = 8'($urandom);
    endtask

    task automatic scramble_pu();
        for (int p = 0; p < NP; p++) pu_mem[p] = 8'($urandom);
    endtask

    task automatic test_reset();
        check(!busy && !done, "R1 reset busy/done", {busy, done}, 0);
        check(!mem_rd && !wr_en, "R1 reset rd/wr", {mem_rd, wr_en}, 0);
    endtask

    task automatic test_main();
        fill_random();
        run_job(0, "R3 R4 R5 R7 seg0 words", 0);
    endtask

    task automatic test_buffered();
        scramble_pu();
        run_job(1, "R8 seg1 from buffer", 0);
        scramble_pu();
        run_job(2, "R8 seg2 from buffer", 0);
        run_job(3, "R8 seg3 from buffer", 0);
        scramble_pu();
        run_job(0, "R8 seg0 recapture", 0);
        scramble_pu();
        run_job(1, "R8 seg1 after recapture", 0);
    endtask

    task automatic test_half();
        for (int p = 0; p < NP; p++)
            rom_mem[3*NP + p] = {1'($urandom), 7'd50, 1'($urandom), 7'd50};
        run_job(3, "R6 count 50", 0);
        for (int p = 0; p < NP; p++)
            check(got[p] == 32'h0, "R6 zero likelihood", got[p], 0);
    endtask

    task automatic test_mirror();
        for (int p = 0; p < NP; p++) begin
            int c;
            c = p % 51;
            if (p >= 120)
                rom_mem[NP + p] = {1'($urandom), 7'(101 + p - 120), 1'($urandom), 7'(127 - (p - 120))};
            else
                rom_mem[NP + p] = {1'($urandom), 7'(100 - c), 1'($urandom), 7'(c)};
        end
        run_job(1, "R7 mirrored and clamped counts", 0);
        check(got[0][31:16] == 16'(-btab(0)) || got[0][31:16] == 16'(btab(0)),
              "R7 count 100 uses entry 0", got[0][31:16], btab(0));
    endtask

    task automatic test_busy_start();
        run_job(2, "R9 start while busy", 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        test_reset();
        test_main();
        test_buffered();
        test_half();
        test_mirror();
        test_busy_start();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            finished = 1;
            nchk++;
            nfail++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    end

endmodule